// File: doc/BRIEF.md
# Subtract-and-Count Unsigned Divider

This block divides one 7-bit unsigned operand by another with a single subtractor and a counter. A start pulse, taken only while the block is idle, copies the dividend and divisor into internal registers. From then on, each clock takes the divisor away from a running remainder and adds one to a count. This goes on for as long as the remainder is still at least as large as the divisor. When the remainder drops below the divisor, the count is the quotient and what is left is the remainder.

The results are registered and stay on the outputs until the next operation finishes. A one-cycle done pulse marks each new result. The number of cycles an operation takes depends on the size of the quotient. A zero divisor is caught in the first working cycle, so the loop never runs without end. The block also provides a 14-bit word holding the quotient with seven zero bits above it. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `subdiv_top`

## Requirements
- R1: After reset the quotient, remainder, result word, done and error outputs are all zero, and the first start is accepted two clock edges after reset is released.
- R2: With a dividend smaller than a nonzero divisor, the result is quotient 0 and remainder equal to the dividend.
- R3: With dividend equal to a nonzero divisor, the result is quotient 1 and remainder 0.
- R4: With a dividend larger than a nonzero divisor, the quotient is the integer floor of A/B and the remainder is A mod B, so that Q*B+R = A and R < B.
- R5: The result word carries the quotient in bits 6:0, and bits 13:7 are always zero.
- R6: A start pulse that arrives while an operation is running is ignored. The result is that of the operands captured at the accepted start.
- R7: A zero divisor ends the operation one cycle after the start edge, with error = 1, quotient all ones (127) and remainder equal to the dividend.
- R8: Done is high for exactly one cycle per operation. Quotient, remainder and error hold their values until the next operation finishes.
- R9: For a nonzero divisor, done rises Q+1 clock edges after the edge that samples start, so the worst case is 128 edges (A = 127, B = 1).
- R10: The error flag is cleared by the next operation that has a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; honoured only when idle |
| dvd_i | input | 7 | Dividend A |
| dvs_i | input | 7 | Divisor B |
| quo_o | output | 7 | Quotient |
| rem_o | output | 7 | Remainder |
| word_o | output | 14 | Quotient zero-extended to 14 bits |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| err_o | output | 1 | Division by zero flagged with the last result |

## Verification
The assertions assume that the operands are meaningful only when they are sampled together with an accepted start, so they check results against the captured copies and not against the live input pins. They also assume that start may be held or pulsed at any time, so the bench deliberately pulses start with different operands during a running operation. The stimulus is random operand pairs drawn over the full 7-bit range, zero divisors included. Directed corner cases are added on top: equal operands, the worst-case 127/1, and zero dividends. Each operation is allowed to finish before a new one begins, except for the deliberate mid-run starts.

// File: rtl/subdiv_pkg.sv
package subdiv_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } subdiv_state_e;
endpackage

// File: rtl/subdiv_rst_sync.sv
module subdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/subdiv_ctrl.sv
module subdiv_ctrl
  import subdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dvs_zero,
  input  logic rem_ge,
  output logic accept,
  output logic step,
  output logic fin_ok,
  output logic fin_zero,
  output logic busy
);
  subdiv_state_e state_q, state_d;

  always_comb begin
    accept   = (state_q == ST_IDLE) && start;
    step     = (state_q == ST_RUN) && !dvs_zero && rem_ge;
    fin_ok   = (state_q == ST_RUN) && !dvs_zero && !rem_ge;
    fin_zero = (state_q == ST_RUN) && dvs_zero;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_RUN;
      ST_RUN:  if (fin_ok || fin_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == ST_RUN);

  // R7: a zero divisor needs exactly one working cycle
  assert_zero_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_zero |=> !busy);
endmodule

// File: rtl/subdiv_datapath.sv
module subdiv_datapath #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         step,
  input  logic         fin_ok,
  input  logic         fin_zero,
  input  logic         busy,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         dvs_zero,
  output logic         rem_ge,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         done_o,
  output logic         err_o
);
  localparam int W2 = 2 * W;

  logic [W-1:0] dvd_q, dvs_q, run_q, cnt_q, quo_q, res_q;
  logic [W-1:0] dvd_d, dvs_d, run_d, cnt_d, quo_d, res_d;
  logic         err_q, err_d, done_q, done_d;
  logic         fin;

  assign fin      = fin_ok || fin_zero;
  assign dvs_zero = (dvs_q == '0);
  assign rem_ge   = (run_q >= dvs_q);

  always_comb begin
    dvd_d  = dvd_q;
    dvs_d  = dvs_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    quo_d  = quo_q;
    res_d  = res_q;
    err_d  = err_q;
    done_d = fin;
    if (accept) begin
      dvd_d = dvd_i;
      dvs_d = dvs_i;
      run_d = dvd_i;
      cnt_d = '0;
    end
    if (step) begin
      run_d = run_q - dvs_q;
      cnt_d = cnt_q + 1'b1;
    end
    if (fin_ok) begin
      quo_d = cnt_q;
      res_d = run_q;
      err_d = 1'b0;
    end
    if (fin_zero) begin
      quo_d = '1;
      res_d = dvd_q;
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      run_q  <= '0;
      cnt_q  <= '0;
      quo_q  <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dvd_q  <= dvd_d;
      dvs_q  <= dvs_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      quo_q  <= quo_d;
      res_q  <= res_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = res_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  // R4: the result is exact and the remainder lies below the divisor
  assert_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !err_q) |->
      (({{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q} + {{W{1'b0}}, res_q}) == W2'({{W{1'b0}}, dvd_q}))
      && (res_q < dvs_q));

  // R7: a zero-divisor result is all ones with the dividend as remainder
  assert_zero_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> (quo_q == '1) && (res_q == dvd_q));

  // R8: done lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: results hold between completions
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(quo_q) && $stable(res_q) && $stable(err_q));

  // R6: captured operands do not change while running
  assert_busy_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dvs_q) && $stable(dvd_q));

  // R9: the count never wraps
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q != '1));
endmodule

// File: rtl/subdiv_top.sv
module subdiv_top #(
  parameter int W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic [2*W-1:0] word_o,
  output logic           done_o,
  output logic           err_o
);
  logic rst_n_s, accept, step, fin_ok, fin_zero, busy, dvs_zero, rem_ge;

  subdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  subdiv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start(start), .dvs_zero(dvs_zero),
    .rem_ge(rem_ge), .accept(accept), .step(step), .fin_ok(fin_ok),
    .fin_zero(fin_zero), .busy(busy)
  );

  subdiv_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .step(step),
    .fin_ok(fin_ok), .fin_zero(fin_zero), .busy(busy),
    .dvd_i(dvd_i), .dvs_i(dvs_i), .dvs_zero(dvs_zero), .rem_ge(rem_ge),
    .quo_o(quo_o), .rem_o(rem_o), .done_o(done_o), .err_o(err_o)
  );

  assign word_o = {{W{1'b0}}, quo_o};

  // R5: upper half of the word is zero
  assert_word_upper_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_o[2*W-1:W] == '0);
endmodule

// File: tb/subdiv_tb_top.sv
module subdiv_tb_top;
  localparam int W = 7;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dvd_i = '0, dvs_i = '0;
  logic [W-1:0] quo_o, rem_o;
  logic [2*W-1:0] word_o;
  logic done_o, err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  subdiv_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dvd_i(dvd_i), .dvs_i(dvs_i),
    .quo_o(quo_o), .rem_o(rem_o), .word_o(word_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic int exp_q(int a, int b);
    if (b == 0) return 127;
    return a / b;
  endfunction

  function automatic int exp_r(int a, int b);
    if (b == 0) return a;
    return a % b;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_div(int a, int b, string req, bit poke = 0);
    int cycles;
    @(negedge clk);
    dvd_i = W'(a);
    dvs_i = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done_o && cycles < 400) begin
      if (poke && cycles == 2) begin
        dvd_i = W'(a ^ 7'h55);
        dvs_i = W'(b + 1);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    check({req, " done seen"}, done_o, 1);
    check({req, " quotient"}, quo_o, exp_q(a, b));
    check({req, " remainder"}, rem_o, exp_r(a, b));
    check({req, " R7 error flag"}, err_o, (b == 0) ? 1 : 0);
    check({req, " R9 latency"}, cycles - 1, (b == 0) ? 1 : exp_q(a, b) + 1);
    check({req, " R5 word"}, int'(word_o), exp_q(a, b));
    @(negedge clk);
    check({req, " R8 done one cycle"}, done_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int ra, rb, q_hold, r_hold;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 quotient", quo_o, 0);
    check("R1 remainder", rem_o, 0);
    check("R1 word", int'(word_o), 0);
    check("R1 done", done_o, 0);
    check("R1 error", err_o, 0);
    @(negedge clk);

    run_div(5, 9, "R2");
    run_div(0, 1, "R2");
    run_div(42, 42, "R3");
    run_div(127, 127, "R3");
    run_div(100, 7, "R4");
    run_div(127, 1, "R4 R9 worst");
    run_div(33, 0, "R7");
    run_div(20, 3, "R10");
    run_div(0, 0, "R7 zero/zero");
    run_div(90, 4, "R6", 1'b1);

    // R8: results hold after done
    q_hold = quo_o;
    r_hold = rem_o;
    repeat (5) @(negedge clk);
    check("R8 hold quotient", quo_o, q_hold);
    check("R8 hold remainder", rem_o, r_hold);
    check("R8 done stays low", done_o, 0);

    for (int i = 0; i < 60; i++) begin
      ra = int'($urandom_range(127, 0));
      rb = (i % 10 == 0) ? 0 : int'($urandom_range(127, 0));
      run_div(ra, rb, "R4 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule